// File: doc/BRIEF.md
# Hybrid Two-Level Branch Direction Predictor

This block predicts branches during instruction fetch. A small set-associative branch target buffer keeps, for every tracked branch, a target address, a short local history and a private table of two-bit saturating counters. On a lookup that hits, the entry's history picks one counter. The upper bit of that counter is the taken/not-taken guess. The history is then shifted at once with that guess, so that back-to-back lookups of a loop branch see the history they would have after earlier instances resolve correctly.

When the buffer misses, a fixed rule based on the branch class and the sign of its displacement supplies the guess. A sixteen-deep return stack, pushed by calls and popped by returns, supplies return targets. Branch resolution reports the real outcome, the history checkpoint returned at prediction time and a mispredict flag. Resolution trains the counter, repairs the history after a wrong guess, and allocates an entry for a branch that missed. The lookup port applies no back-pressure: every lookup presented with `lk_valid` is accepted, and its prediction is valid combinationally in the same cycle, flagged by `pr_valid`. Resolve updates are also always accepted.

Top module: `bp_top`

## Requirements
- R1: Branch class codes on `lk_class` are 0 conditional, 1 unconditional relative, 2 call, 3 return, 4 indirect; any other code is treated like indirect. On a buffer miss, classes 1, 2 and 3 predict taken.
- R2: On a buffer miss, a conditional branch predicts taken when `lk_disp_neg` is 1 (backward) and not taken when it is 0 (forward).
- R3: On a buffer miss, an indirect branch, or a branch with any unlisted class code, predicts not taken.
- R4: On a hit, `pr_taken` is bit 1 of the entry's counter selected by its current 4-bit history, and `pr_hist` shows that history. On a miss, `pr_hist` is 0 and `pr_hit` is 0.
- R5: A lookup that hits shifts the entry's history left by one bit in the next cycle, with `pr_taken` entering at bit 0.
- R6: A resolve that hits updates the counter indexed by `rs_hist`: it counts up on taken and down on not taken, and saturates at 0 and 3.
- R7: A resolve that hits with `rs_mispred`=1 sets the history to `{rs_hist[2:0], rs_taken}`. With `rs_mispred`=0 the history is left unchanged.
- R8: A resolve that misses allocates an entry in the set chosen by the low PC bits. It takes the first invalid way, otherwise the way named by a per-set rotating pointer that advances on each allocation. The new entry has history 0, all counters 1 (weakly not taken) and target `rs_target`.
- R9: `pr_target` is the return-stack top for class 3. Otherwise it is the stored target on a hit, and `lk_static_tgt` on a miss.
- R10: A call lookup pushes `lk_ret_addr` and a return lookup pops it, last in first out. The stack holds 16 addresses, and a seventeenth push overwrites the oldest.
- R11: After reset every buffer entry is invalid, every return-stack slot holds 0 and the stack pointer is 0.
- R12: `pr_valid` follows `lk_valid` in the same cycle, and the lookup port never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | PC_W | Fetch address of the branch |
| lk_class | input | 3 | Branch class code |
| lk_disp_neg | input | 1 | Displacement is negative |
| lk_static_tgt | input | PC_W | Target computed by the decoder, used on a miss |
| lk_ret_addr | input | PC_W | Return address pushed by a call |
| pr_valid | output | 1 | Prediction valid |
| pr_hit | output | 1 | Target buffer hit |
| pr_taken | output | 1 | Predicted direction |
| pr_target | output | PC_W | Predicted target |
| pr_hist | output | HIST_W | History checkpoint to carry with the branch |
| rs_valid | input | 1 | Resolve update present |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome |
| rs_mispred | input | 1 | Prediction was wrong |
| rs_hist | input | HIST_W | Checkpoint returned at prediction time |
| rs_target | input | PC_W | Actual target |

## Verification
The properties assume that a lookup and a resolve never name the same entry in the same cycle. They also assume that `rs_hist` is the `pr_hist` value the branch received, and that a lookup-to-lookup history check is never broken by a resolve in between. The stimulus keeps to this by driving lookups and resolves in separate cycles, and it builds every `rs_hist` from the checkpoints the bench itself expects. Miss-path rules are checked on addresses that no resolve has ever allocated, so the static rule alone decides them.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [2:0] {
    BR_COND   = 3'd0,
    BR_UNCOND = 3'd1,
    BR_CALL   = 3'd2,
    BR_RET    = 3'd3,
    BR_IND    = 3'd4
  } br_class_e;

  localparam logic [1:0] CTR_WEAK_NT = 2'b01;

  // Two-bit saturating step.
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

endpackage

// File: rtl/bp_static_rule.sv
module bp_static_rule
  import bp_pkg::*;
(
  input  logic [2:0] cls,
  input  logic       disp_neg,
  output logic       taken
);

  always_comb begin
    unique case (cls)
      BR_COND:                   taken = disp_neg;
      BR_UNCOND, BR_CALL, BR_RET: taken = 1'b1;
      default:                   taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
  parameter int DEPTH = 16,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] slot [DEPTH];
  logic [PW-1:0] ptr;
  logic [PW-1:0] ptr_m1;

  assign ptr_m1 = ptr - 1'b1;
  assign top    = slot[ptr_m1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (push) begin
      slot[ptr] <= push_data;
      ptr       <= ptr + 1'b1;
    end else if (pop) begin
      ptr <= ptr_m1;
    end
  end

endmodule

// File: rtl/bp_btb.sv
module bp_btb
  import bp_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int HIST_W = 4,
  parameter int TAG_W  = 14,
  parameter int AW     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(SETS)-1:0]      lk_idx,
  input  logic [TAG_W-1:0]             lk_tag,
  output logic                         lk_hit,
  output logic [HIST_W-1:0]            lk_hist,
  output logic                         lk_ctr_msb,
  output logic [AW-1:0]                lk_target,
  input  logic                         spec_en,
  input  logic                         spec_bit,
  input  logic                         rs_valid,
  input  logic [$clog2(SETS)-1:0]      rs_idx,
  input  logic [TAG_W-1:0]             rs_tag,
  input  logic                         rs_taken,
  input  logic                         rs_mispred,
  input  logic [HIST_W-1:0]            rs_hist,
  input  logic [AW-1:0]                rs_target
);

  localparam int CTRS  = 1 << HIST_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic              vld  [SETS][WAYS];
  logic [TAG_W-1:0]  tagm [SETS][WAYS];
  logic [AW-1:0]     tgtm [SETS][WAYS];
  logic [HIST_W-1:0] hist [SETS][WAYS];
  logic [1:0]        ctr  [SETS][WAYS][CTRS];
  logic [WAY_W-1:0]  rr   [SETS];

  logic [WAY_W-1:0]  lk_way;
  logic              rs_hit;
  logic [WAY_W-1:0]  rs_way;
  logic [WAY_W-1:0]  victim;
  logic              free_found;

  // Lookup port match.
  always_comb begin
    lk_hit = 1'b0;
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[lk_idx][w] && tagm[lk_idx][w] == lk_tag) begin
        lk_hit = 1'b1;
        lk_way = WAY_W'(w);
      end
    end
  end

  assign lk_hist    = lk_hit ? hist[lk_idx][lk_way] : '0;
  assign lk_ctr_msb = lk_hit & ctr[lk_idx][lk_way][lk_hist][1];
  assign lk_target  = tgtm[lk_idx][lk_way];

  // Resolve port match and victim choice.
  always_comb begin
    rs_hit = 1'b0;
    rs_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[rs_idx][w] && tagm[rs_idx][w] == rs_tag) begin
        rs_hit = 1'b1;
        rs_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    victim     = rr[rs_idx];
    free_found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!free_found && !vld[rs_idx][w]) begin
        victim     = WAY_W'(w);
        free_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        rr[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w]  <= 1'b0;
          tagm[s][w] <= '0;
          tgtm[s][w] <= '0;
          hist[s][w] <= '0;
          for (int c = 0; c < CTRS; c++) ctr[s][w][c] <= CTR_WEAK_NT;
        end
      end
    end else begin
      // Speculative shift at prediction time.
      if (spec_en)
        hist[lk_idx][lk_way] <= {hist[lk_idx][lk_way][HIST_W-2:0], spec_bit};
      // Resolve writes come later and win on a shared entry.
      if (rs_valid) begin
        if (rs_hit) begin
          ctr[rs_idx][rs_way][rs_hist] <= ctr_step(ctr[rs_idx][rs_way][rs_hist], rs_taken);
          if (rs_mispred)
            hist[rs_idx][rs_way] <= {rs_hist[HIST_W-2:0], rs_taken};
        end else begin
          vld[rs_idx][victim]  <= 1'b1;
          tagm[rs_idx][victim] <= rs_tag;
          tgtm[rs_idx][victim] <= rs_target;
          hist[rs_idx][victim] <= '0;
          for (int c = 0; c < CTRS; c++) ctr[rs_idx][victim][c] <= CTR_WEAK_NT;
          rr[rs_idx] <= (rr[rs_idx] == WAY_W'(WAYS - 1)) ? '0 : rr[rs_idx] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bp_top.sv
module bp_top
  import bp_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int SETS      = 4,
  parameter int WAYS      = 2,
  parameter int HIST_W    = 4,
  parameter int RAS_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [2:0]        lk_class,
  input  logic              lk_disp_neg,
  input  logic [PC_W-1:0]   lk_static_tgt,
  input  logic [PC_W-1:0]   lk_ret_addr,
  output logic              pr_valid,
  output logic              pr_hit,
  output logic              pr_taken,
  output logic [PC_W-1:0]   pr_target,
  output logic [HIST_W-1:0] pr_hist,
  input  logic              rs_valid,
  input  logic [PC_W-1:0]   rs_pc,
  input  logic              rs_taken,
  input  logic              rs_mispred,
  input  logic [HIST_W-1:0] rs_hist,
  input  logic [PC_W-1:0]   rs_target
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PC_W - IDX_W;

  logic            btb_hit;
  logic            btb_msb;
  logic [PC_W-1:0] btb_tgt;
  logic            static_taken;
  logic [PC_W-1:0] ras_top;
  logic            is_call;
  logic            is_ret;

  assign is_call = (lk_class == BR_CALL);
  assign is_ret  = (lk_class == BR_RET);

  bp_btb #(
    .SETS(SETS), .WAYS(WAYS), .HIST_W(HIST_W), .TAG_W(TAG_W), .AW(PC_W)
  ) u_btb (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_idx     (lk_pc[IDX_W-1:0]),
    .lk_tag     (lk_pc[PC_W-1:IDX_W]),
    .lk_hit     (btb_hit),
    .lk_hist    (pr_hist),
    .lk_ctr_msb (btb_msb),
    .lk_target  (btb_tgt),
    .spec_en    (lk_valid & btb_hit),
    .spec_bit   (btb_msb),
    .rs_valid   (rs_valid),
    .rs_idx     (rs_pc[IDX_W-1:0]),
    .rs_tag     (rs_pc[PC_W-1:IDX_W]),
    .rs_taken   (rs_taken),
    .rs_mispred (rs_mispred),
    .rs_hist    (rs_hist),
    .rs_target  (rs_target)
  );

  bp_static_rule u_static (
    .cls      (lk_class),
    .disp_neg (lk_disp_neg),
    .taken    (static_taken)
  );

  bp_ras #(.DEPTH(RAS_DEPTH), .AW(PC_W)) u_ras (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (lk_valid & is_call),
    .pop       (lk_valid & is_ret),
    .push_data (lk_ret_addr),
    .top       (ras_top)
  );

  assign pr_valid  = lk_valid;
  assign pr_hit    = btb_hit;
  assign pr_taken  = btb_hit ? btb_msb : static_taken;
  assign pr_target = is_ret ? ras_top : (btb_hit ? btb_tgt : lk_static_tgt);

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int PC_W   = 16,
  parameter int HIST_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [PC_W-1:0]   lk_pc,
  input logic [2:0]        lk_class,
  input logic              lk_disp_neg,
  input logic [PC_W-1:0]   lk_ret_addr,
  input logic              pr_hit,
  input logic              pr_taken,
  input logic [PC_W-1:0]   pr_target,
  input logic [HIST_W-1:0] pr_hist,
  input logic              rs_valid
);

  a_r1_miss_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !pr_hit && (lk_class == 3'd1 || lk_class == 3'd2 || lk_class == 3'd3))
      |-> pr_taken);

  a_r2_miss_cond_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !pr_hit && lk_class == 3'd0) |-> (pr_taken == lk_disp_neg));

  a_r3_miss_indirect_nt: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !pr_hit && lk_class >= 3'd4) |-> !pr_taken);

  a_r4_miss_hist_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !pr_hit) |-> (pr_hist == '0));

  a_r5_spec_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && pr_hit && $past(lk_valid && pr_hit && !rs_valid) && lk_pc == $past(lk_pc))
      |-> (pr_hist == {$past(pr_hist[HIST_W-2:0]), $past(pr_taken)}));

  a_r10_call_ret_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_valid && lk_class == 3'd2) && lk_valid && lk_class == 3'd3)
      |-> (pr_target == $past(lk_ret_addr)));

endmodule

bind bp_top bp_checker #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_pc       (lk_pc),
  .lk_class    (lk_class),
  .lk_disp_neg (lk_disp_neg),
  .lk_ret_addr (lk_ret_addr),
  .pr_hit      (pr_hit),
  .pr_taken    (pr_taken),
  .pr_target   (pr_target),
  .pr_hist     (pr_hist),
  .rs_valid    (rs_valid)
);

// File: tb/sim_bp_top.sv
module sim_bp_top;
  import bp_pkg::*;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_pc = '0;
  logic [2:0]  lk_class = '0;
  logic        lk_disp_neg = 1'b0;
  logic [15:0] lk_static_tgt = '0;
  logic [15:0] lk_ret_addr = '0;
  logic        pr_valid, pr_hit, pr_taken;
  logic [15:0] pr_target;
  logic [3:0]  pr_hist;
  logic        rs_valid = 1'b0;
  logic [15:0] rs_pc = '0;
  logic        rs_taken = 1'b0;
  logic        rs_mispred = 1'b0;
  logic [3:0]  rs_hist = '0;
  logic [15:0] rs_target = '0;

  int n_chk = 0;
  int n_err = 0;
  logic s_valid, s_hit, s_taken;
  logic [15:0] s_tgt;
  logic [3:0]  s_hist;

  always #(CLK_P/2) clk = ~clk;

  bp_top u0 (.*);

  // {class, disp_neg, pc, static_tgt, expected taken}
  localparam logic [36:0] VEC [6] = '{
    {3'd0, 1'b1, 16'h0402, 16'h03F0, 1'b1},
    {3'd0, 1'b0, 16'h0406, 16'h0480, 1'b0},
    {3'd1, 1'b0, 16'h040A, 16'h0800, 1'b1},
    {3'd4, 1'b1, 16'h040E, 16'h0123, 1'b0},
    {3'd5, 1'b1, 16'h0412, 16'h0222, 1'b0},
    {3'd1, 1'b1, 16'h0416, 16'h0010, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input logic [15:0] pc, input logic [2:0] cls, input logic neg,
                      input logic [15:0] stgt, input logic [15:0] ret);
    lk_valid = 1'b1; lk_pc = pc; lk_class = cls; lk_disp_neg = neg;
    lk_static_tgt = stgt; lk_ret_addr = ret;
    #1;
    s_valid = pr_valid; s_hit = pr_hit; s_taken = pr_taken; s_tgt = pr_target; s_hist = pr_hist;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic resolve(input logic [15:0] pc, input logic tk, input logic mis,
                         input logic [3:0] h, input logic [15:0] tgt);
    rs_valid = 1'b1; rs_pc = pc; rs_taken = tk; rs_mispred = mis; rs_hist = h; rs_target = tgt;
    @(negedge clk);
    rs_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 / R12: idle after reset
    #1;
    chk("R12 idle pr_valid", pr_valid, 0);
    @(negedge clk);
    look(16'h0F03, 3'd3, 1'b0, 16'h0AAA, 16'h0);
    chk("R11 empty stack target", s_tgt, 16'h0000);
    chk("R11 no valid entry", s_hit, 0);
    chk("R12 pr_valid with lookup", s_valid, 1);

    // Static rule table (R1 R2 R3 R9)
    for (int i = 0; i < 6; i++) begin
      look(VEC[i][32:17], VEC[i][36:34], VEC[i][33], VEC[i][16:1], 16'h0);
      chk("R2/R3/R1 miss taken", s_taken, VEC[i][0]);
      chk("R9 miss target static", s_tgt, VEC[i][16:1]);
      chk("R4 miss hit flag", s_hit, 0);
      chk("R4 miss hist zero", s_hist, 0);
    end

    // Entry A: allocation, speculative history, repair (R4 R5 R7 R8)
    resolve(16'h0010, 1'b1, 1'b0, 4'h0, 16'h0100);
    look(16'h0010, 3'd0, 1'b0, 16'h0999, 16'h0);
    chk("R8 alloc hit", s_hit, 1);
    chk("R8 alloc hist", s_hist, 0);
    chk("R8 weak not taken", s_taken, 0);
    chk("R9 hit target", s_tgt, 16'h0100);
    resolve(16'h0010, 1'b1, 1'b1, 4'h0, 16'h0100);
    begin
      logic [3:0] eh [6] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h0, 4'h1};
      logic       et [6] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      for (int k = 0; k < 6; k++) begin
        look(16'h0010, 3'd0, 1'b0, 16'h0999, 16'h0);
        chk("R5 R7 spec hist", s_hist, eh[k]);
        chk("R4 counter msb", s_taken, et[k]);
      end
    end
    resolve(16'h0010, 1'b0, 1'b0, 4'h3, 16'h0100);
    look(16'h0010, 3'd0, 1'b0, 16'h0999, 16'h0);
    chk("R7 no repair without mispredict", s_hist, 4'h2);

    // Entry B: saturation (R6)
    resolve(16'h0021, 1'b0, 1'b0, 4'h0, 16'h0200);
    resolve(16'h0021, 1'b0, 1'b0, 4'h0, 16'h0200);
    resolve(16'h0021, 1'b0, 1'b0, 4'h0, 16'h0200);
    resolve(16'h0021, 1'b1, 1'b0, 4'h0, 16'h0200);
    look(16'h0021, 3'd0, 1'b1, 16'h0999, 16'h0);
    chk("R6 low saturation", s_taken, 0);
    chk("R6 hist unchanged", s_hist, 0);
    resolve(16'h0021, 1'b1, 1'b0, 4'h0, 16'h0200);
    resolve(16'h0021, 1'b1, 1'b0, 4'h0, 16'h0200);
    resolve(16'h0021, 1'b1, 1'b0, 4'h0, 16'h0200);
    look(16'h0021, 3'd0, 1'b0, 16'h0999, 16'h0);
    chk("R6 high saturation", s_taken, 1);
    chk("R9 B target", s_tgt, 16'h0200);

    // Replacement in set 0 (R8)
    resolve(16'h0030, 1'b1, 1'b0, 4'h0, 16'h0300);
    resolve(16'h0050, 1'b1, 1'b0, 4'h0, 16'h0500);
    look(16'h0010, 3'd0, 1'b0, 16'h0777, 16'h0);
    chk("R8 oldest way replaced", s_hit, 0);
    look(16'h0030, 3'd0, 1'b0, 16'h0777, 16'h0);
    chk("R8 other way kept", s_hit, 1);
    chk("R8 kept target", s_tgt, 16'h0300);
    look(16'h0050, 3'd0, 1'b0, 16'h0777, 16'h0);
    chk("R8 new entry hit", s_hit, 1);
    chk("R8 new entry target", s_tgt, 16'h0500);

    // Return stack (R1 R10)
    look(16'h0F03, 3'd2, 1'b0, 16'h0700, 16'h1111);
    chk("R1 call miss taken", s_taken, 1);
    chk("R9 call target", s_tgt, 16'h0700);
    look(16'h0F03, 3'd2, 1'b0, 16'h0700, 16'h2222);
    look(16'h0F03, 3'd3, 1'b0, 16'h0700, 16'h0);
    chk("R10 pop newest", s_tgt, 16'h2222);
    chk("R1 return taken", s_taken, 1);
    look(16'h0F03, 3'd3, 1'b0, 16'h0700, 16'h0);
    chk("R10 pop older", s_tgt, 16'h1111);
    for (int i = 0; i < 17; i++)
      look(16'h0F03, 3'd2, 1'b0, 16'h0700, 16'h3000 + 16'(i));
    for (int i = 0; i < 17; i++) begin
      look(16'h0F03, 3'd3, 1'b0, 16'h0700, 16'h0);
      chk("R10 wrap order", s_tgt, (i < 16) ? 16'h3010 - 16'(i) : 16'h3010);
    end

    finish_run();
  end

endmodule